// File: doc/BRIEF.md
# ACPI Sleep-State Power Sequencer

This block decides which supply rails of a memory and graphics subsystem are allowed to run. It watches two active-low sleep requests and two supply power-on-reset flags. From them it settles into one of three system states: fully off (S5), suspended to memory (S3) or working (S0). It drives one enable per regulator channel. The channels are the memory core rail, the graphics core rail, two linear rails (termination/CPU and DAC) and the memory termination rail. It also drives an error-amplifier reset strobe, a switch that shorts the termination reference so that rail floats, and the pull-down of an open-drain power-good pin.

An external timer supplies a one-cycle pulse at the end of every soft-start cycle. The regulators report their in-regulation flags. The sequencer holds the amplifiers in reset for a number of soft-start cycles. It then brings the rails up one stage at a time and only arms power-good once the last rail has had a soft-start cycle to settle. In S3 the memory core rail stays powered and keeps its enable through the next resume. A drop of the off request or of the standby supply tears everything down at once.

Top module: `pwrseq_top`

## Requirements
- R1: While reset is held, and directly after it, `sleepState` reads 0 (encoding S5=0, S3=1, S0=2). All five `railEn` bits are 0, `ampReset` is 0, `refShort` is 1 and `pgDriveLow` is 1.
- R2: Each of `slpS3N`, `slpS5N`, `stbyOk` and `mainOk` passes through a two-flop synchronizer. The block leaves S5 for S0 on the third rising edge after the last of these four is high. On that edge `sleepState` becomes 2 and `ampReset` rises.
- R3: `ampReset` stays high, with no rail newly enabled, until the third `ssTick` pulse counted after entry. On the edge of that pulse `ampReset` falls and `railEn[0]` (memory core) is set.
- R4: The enables come up in this order: `railEn[1]` (graphics) on the edge after `inRegOk[0]` is seen, then `railEn[2]` and `railEn[3]` together on the edge after `inRegOk[1]` is seen, then `railEn[4]` (memory termination) on the edge after both `inRegOk[2]` and `inRegOk[3]` are seen. A flag raised before its stage is reached has no effect.
- R5: `refShort` is 1 whenever `railEn[4]` is 0. It falls on the same edge that sets `railEn[4]`.
- R6: Power-good is armed on the first `ssTick` after `railEn[4]` is set. Once armed, `pgDriveLow` equals the inverse of `inRegOk[2]` with no clock delay.
- R7: `slpS3N` low with `slpS5N` high, from any S0 stage, moves the block to S3 (`sleepState`=1). On that edge `railEn[4:1]` clear, `ampReset` clears, `refShort` sets and power-good is disarmed. `railEn[0]` keeps its value. The sleep request wins over a stage step, such as a reset-ending `ssTick`, that falls in the same cycle.
- R8: From S3, `slpS3N` high together with `mainOk` high starts the same amplifier reset and staged sequence. `railEn[0]` stays 1 throughout.
- R9: `slpS5N` low or `stbyOk` low, from any state, moves the block to S5 on the edge after synchronization. All enables clear at once, `ampReset` clears, `refShort` sets and power-good is disarmed.
- R10: `pgDriveLow` is 1 in every state other than S0.
- R11: In S3, `slpS3N` returning high while `mainOk` is low keeps the block in S3 with the memory core rail still enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slpS3N | input | 1 | Active-low suspend-to-memory request, asynchronous |
| slpS5N | input | 1 | Active-low power-off request, asynchronous |
| stbyOk | input | 1 | Standby supply past power-on reset, asynchronous |
| mainOk | input | 1 | 12 V supply past power-on reset, asynchronous |
| ssTick | input | 1 | One-cycle pulse at the end of each soft-start cycle |
| inRegOk | input | 4 | In-regulation flags: 0 memory core, 1 graphics, 2 termination/CPU linear, 3 DAC linear |
| railEn | output | 5 | Enables: 0 memory core, 1 graphics, 2 termination/CPU linear, 3 DAC linear, 4 memory termination |
| ampReset | output | 1 | Error-amplifier reset (compensation tied to feedback) |
| refShort | output | 1 | Shorts the termination reference so the termination rail floats |
| pgDriveLow | output | 1 | Pulls the open-drain power-good pin low when 1 |
| sleepState | output | 2 | Current state: 0 S5, 1 S3, 2 S0 |

## Verification
The sharpest collision is a sleep request reaching the state machine in the cycle where the third soft-start tick would end the amplifier reset. The bench lowers `slpS3N` two cycles before it pulses `ssTick`, so both arrive at the same edge after synchronization. The reference model requires S3 with no rail step, and the block must match. A second overlap, the S5 request against any S0 or S3 step, is provoked by dropping `slpS5N` or `stbyOk` in mid-sequence. The model is compared with every output on every clock.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int NUM_RAILS = 5;
  localparam int NUM_MON   = 4;

  localparam int CH_CORE = 0;
  localparam int CH_GFX  = 1;
  localparam int CH_LINA = 2;
  localparam int CH_LINB = 3;
  localparam int CH_TERM = 4;

  localparam logic [1:0] ACPI_S5 = 2'd0;
  localparam logic [1:0] ACPI_S3 = 2'd1;
  localparam logic [1:0] ACPI_S0 = 2'd2;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SLEEP,
    ST_AMPRST,
    ST_CORE,
    ST_GFX,
    ST_LIN,
    ST_TERM,
    ST_ACTIVE
  } seqState_t;

  typedef struct packed {
    logic allOff;
    logic sleepOff;
    logic startRst;
    logic coreOn;
    logic gfxOn;
    logic linOn;
    logic termOn;
    logic pgArm;
    logic cntClr;
  } seqStrobe_t;

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= '0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int RST_CYCLES = 3,
  parameter int PG_CYCLES  = 1,
  parameter int CW         = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               s3Ok,
  input  logic               s5Ok,
  input  logic               stbyOk,
  input  logic               mainOk,
  input  logic               ssTick,
  input  logic [NUM_MON-1:0] inRegOk,
  input  logic [CW-1:0]      tickCnt,
  output seqStrobe_t         stb,
  output logic [1:0]         sleepState
);

  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYCLES - 1);
  localparam logic [CW-1:0] PG_LAST  = CW'(PG_CYCLES - 1);

  seqState_t stateQ, stateD;
  logic      rstDone, pgDone, wakeReq;

  assign rstDone = ssTick && (tickCnt == RST_LAST);
  assign pgDone  = ssTick && (tickCnt == PG_LAST);
  assign wakeReq = s3Ok && mainOk;

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    if (!stbyOk || !s5Ok) begin
      stateD     = ST_OFF;
      stb.allOff = 1'b1;
    end else begin
      unique case (stateQ)
        ST_OFF, ST_SLEEP: begin
          if (wakeReq) begin
            stateD       = ST_AMPRST;
            stb.startRst = 1'b1;
            stb.cntClr   = 1'b1;
          end
        end
        default: begin
          if (!s3Ok) begin
            stateD       = ST_SLEEP;
            stb.sleepOff = 1'b1;
          end else begin
            unique case (stateQ)
              ST_AMPRST: if (rstDone) begin
                stateD     = ST_CORE;
                stb.coreOn = 1'b1;
              end
              ST_CORE: if (inRegOk[CH_CORE]) begin
                stateD    = ST_GFX;
                stb.gfxOn = 1'b1;
              end
              ST_GFX: if (inRegOk[CH_GFX]) begin
                stateD    = ST_LIN;
                stb.linOn = 1'b1;
              end
              ST_LIN: if (inRegOk[CH_LINA] && inRegOk[CH_LINB]) begin
                stateD     = ST_TERM;
                stb.termOn = 1'b1;
                stb.cntClr = 1'b1;
              end
              ST_TERM: if (pgDone) begin
                stateD    = ST_ACTIVE;
                stb.pgArm = 1'b1;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateD;
  end

  always_comb begin
    unique case (stateQ)
      ST_OFF:   sleepState = ACPI_S5;
      ST_SLEEP: sleepState = ACPI_S3;
      default:  sleepState = ACPI_S0;
    endcase
  end

endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int CW    = 2,
  parameter int MAX_T = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           stb,
  input  logic                 ssTick,
  input  logic                 termCpuOk,
  output logic [NUM_RAILS-1:0] railEn,
  output logic                 ampReset,
  output logic                 refShort,
  output logic                 pgDriveLow,
  output logic [CW-1:0]        tickCnt
);

  logic [NUM_RAILS-1:0] railSet, railClr;
  logic                 pgArmQ;

  always_comb begin
    railSet = '0;
    railClr = '0;
    railSet[CH_CORE] = stb.coreOn;
    railSet[CH_GFX]  = stb.gfxOn;
    railSet[CH_LINA] = stb.linOn;
    railSet[CH_LINB] = stb.linOn;
    railSet[CH_TERM] = stb.termOn;
    for (int i = 0; i < NUM_RAILS; i++) begin
      if (stb.allOff || (stb.sleepOff && i != CH_CORE)) railClr[i] = 1'b1;
    end
  end

  generate
    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           railEn[r] <= 1'b0;
        else if (railClr[r]) railEn[r] <= 1'b0;
        else if (railSet[r]) railEn[r] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ampReset <= 1'b0;
      refShort <= 1'b1;
      pgArmQ   <= 1'b0;
    end else if (stb.allOff || stb.sleepOff) begin
      ampReset <= 1'b0;
      refShort <= 1'b1;
      pgArmQ   <= 1'b0;
    end else begin
      if (stb.startRst) ampReset <= 1'b1;
      if (stb.coreOn)   ampReset <= 1'b0;
      if (stb.termOn)   refShort <= 1'b0;
      if (stb.pgArm)    pgArmQ   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          tickCnt <= '0;
    else if (stb.cntClr)                tickCnt <= '0;
    else if (ssTick && tickCnt != CW'(MAX_T)) tickCnt <= tickCnt + CW'(1);
  end

  assign pgDriveLow = !(pgArmQ && termCpuOk);

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int RST_CYCLES  = 3,
  parameter int PG_CYCLES   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slpS3N,
  input  logic       slpS5N,
  input  logic       stbyOk,
  input  logic       mainOk,
  input  logic       ssTick,
  input  logic [3:0] inRegOk,
  output logic [4:0] railEn,
  output logic       ampReset,
  output logic       refShort,
  output logic       pgDriveLow,
  output logic [1:0] sleepState
);

  localparam int MAX_T = (RST_CYCLES > PG_CYCLES) ? RST_CYCLES : PG_CYCLES;
  localparam int CW    = $clog2(MAX_T + 1);

  logic [3:0]  syncVec;
  logic [CW-1:0] tickCnt;
  seqStrobe_t  stb;

  pwrseq_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({slpS3N, slpS5N, stbyOk, mainOk}),
    .syncOut (syncVec)
  );

  pwrseq_ctrl #(.RST_CYCLES(RST_CYCLES), .PG_CYCLES(PG_CYCLES), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .s3Ok       (syncVec[3]),
    .s5Ok       (syncVec[2]),
    .stbyOk     (syncVec[1]),
    .mainOk     (syncVec[0]),
    .ssTick     (ssTick),
    .inRegOk    (inRegOk),
    .tickCnt    (tickCnt),
    .stb        (stb),
    .sleepState (sleepState)
  );

  pwrseq_dp #(.CW(CW), .MAX_T(MAX_T)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .ssTick     (ssTick),
    .termCpuOk  (inRegOk[CH_LINA]),
    .railEn     (railEn),
    .ampReset   (ampReset),
    .refShort   (refShort),
    .pgDriveLow (pgDriveLow),
    .tickCnt    (tickCnt)
  );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] inRegOk,
  input logic [4:0] railEn,
  input logic       ampReset,
  input logic       refShort,
  input logic       pgDriveLow,
  input logic [1:0] sleepState
);

  // R5
  ref_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    !railEn[4] |-> refShort);

  // R10
  pg_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepState != 2'd2) |-> pgDriveLow);

  // R3
  amp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ampReset |-> (railEn[4:1] == 4'b0));

  // R4
  order_gfx_chk: assert property (@(posedge clk) disable iff (!rstN)
    railEn[1] |-> railEn[0]);

  // R4
  order_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    railEn[4] |-> (railEn[3] && railEn[2] && railEn[1]));

  // R4
  gfx_after_core_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(railEn[1]) |-> $past(inRegOk[0]));

  // R9
  off_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepState == 2'd0) |-> (railEn == 5'b0 && !ampReset));

  // R7
  sleep_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepState == 2'd1) |-> (railEn[4:1] == 4'b0 && !ampReset));

endmodule

bind pwrseq_top pwrseq_chk u_chk (.*);

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;

  localparam int RSTC = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, slpS3N, slpS5N, stbyOk, mainOk, ssTick;
  logic [3:0] inRegOk;
  logic [4:0] railEn;
  logic       ampReset, refShort, pgDriveLow;
  logic [1:0] sleepState;

  pwrseq_top u0 (.*);

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  // behavioural reference
  int         mSt;   // 0 off 1 sleep 2 ampreset 3..6 stages 7 active
  logic [4:0] mEn;
  logic       mAr, mRs, mArm;
  int         mCnt;
  logic [3:0] q1, q2;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mEn = '0; mAr = 0; mRs = 1; mArm = 0; mCnt = 0; q1 = '0; q2 = '0;
    end else begin
      logic s3, s5, sb, mo, clr;
      {s3, s5, sb, mo} = q2;
      clr = 0;
      if (!sb || !s5) begin
        mSt = 0; mEn = '0; mAr = 0; mRs = 1; mArm = 0;
      end else if (mSt <= 1) begin
        if (s3 && mo) begin mSt = 2; mAr = 1; clr = 1; end
      end else if (!s3) begin
        mSt = 1; mEn[4:1] = '0; mAr = 0; mRs = 1; mArm = 0;
      end else begin
        case (mSt)
          2: if (ssTick && mCnt == RSTC - 1) begin mSt = 3; mAr = 0; mEn[0] = 1; end
          3: if (inRegOk[0]) begin mSt = 4; mEn[1] = 1; end
          4: if (inRegOk[1]) begin mSt = 5; mEn[3:2] = 2'b11; end
          5: if (inRegOk[2] && inRegOk[3]) begin mSt = 6; mEn[4] = 1; mRs = 0; clr = 1; end
          6: if (ssTick && mCnt == 0) begin mSt = 7; mArm = 1; end
          default: ;
        endcase
      end
      if (clr) mCnt = 0;
      else if (ssTick && mCnt < RSTC) mCnt++;
      q2 = q1;
      q1 = {slpS3N, slpS5N, stbyOk, mainOk};
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !ended) begin
      chk("R4 model railEn", railEn, mEn);
      chk("R3 model ampReset", ampReset, mAr);
      chk("R5 model refShort", refShort, mRs);
      chk("R6 model pgDriveLow", pgDriveLow, !(mArm && inRegOk[2]));
      chk("R2 model sleepState", sleepState, (mSt <= 1) ? mSt : 2);
    end
  end

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic tick();
    ssTick = 1'b1;
    @(negedge clk);
    ssTick = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 0; slpS3N = 0; slpS5N = 0; stbyOk = 0; mainOk = 0; ssTick = 0; inRegOk = '0;
    waitN(2);
    // R1 reset state
    chk("R1 sleepState", sleepState, 0);
    chk("R1 railEn", railEn, 0);
    chk("R1 ampReset", ampReset, 0);
    chk("R1 refShort", refShort, 1);
    chk("R1 pgDriveLow", pgDriveLow, 1);
    rstN = 1;
    waitN(1);
    chk("R1 after release", sleepState, 0);

    stbyOk = 1; slpS5N = 1; slpS3N = 1;
    waitN(6);
    chk("R2 waits for mainOk", sleepState, 0);
    mainOk = 1;
    waitN(1);
    chk("R2 sync latency 1", sleepState, 0);
    waitN(1);
    chk("R2 sync latency 2", sleepState, 0);
    waitN(1);
    chk("R2 enters S0", sleepState, 2);
    chk("R2 amp reset up", ampReset, 1);

    tick(); waitN(2); tick();
    chk("R3 still in reset", ampReset, 1);
    chk("R3 no rail yet", railEn, 0);
    inRegOk = 4'b0010;
    tick();
    chk("R3 reset ends", ampReset, 0);
    chk("R3 core enabled", railEn, 5'b00001);
    waitN(3);
    chk("R4 early gfx flag ignored", railEn, 5'b00001);
    inRegOk = 4'b0011;
    waitN(1);
    chk("R4 gfx stage", railEn, 5'b00011);
    waitN(1);
    chk("R4 linear pair", railEn, 5'b01111);
    chk("R5 ref still shorted", refShort, 1);
    inRegOk = 4'b1111;
    waitN(1);
    chk("R4 termination", railEn, 5'b11111);
    chk("R5 ref released", refShort, 0);
    chk("R6 not armed yet", pgDriveLow, 1);
    tick();
    chk("R6 armed good", pgDriveLow, 0);
    inRegOk[2] = 1'b0;
    #1;
    chk("R6 follows flag", pgDriveLow, 1);
    inRegOk[2] = 1'b1;
    waitN(1);

    slpS3N = 0;
    waitN(3);
    chk("R7 in S3", sleepState, 1);
    chk("R7 core kept", railEn, 5'b00001);
    chk("R10 pg low in S3", pgDriveLow, 1);
    chk("R7 ref shorted", refShort, 1);

    mainOk = 0; slpS3N = 1;
    waitN(6);
    chk("R11 stays S3", sleepState, 1);
    chk("R11 core still on", railEn, 5'b00001);
    mainOk = 1;
    waitN(3);
    chk("R8 resume reset", ampReset, 1);
    chk("R8 core during reset", railEn, 5'b00001);
    tick(); tick(); tick();
    chk("R8 core unchanged", railEn, 5'b00001);
    waitN(4);
    chk("R8 resumed stages", railEn, 5'b11111);
    tick();
    chk("R8 pg good again", pgDriveLow, 0);

    // collision: sleep request with reset-ending tick
    slpS3N = 0; waitN(3);
    slpS3N = 1; waitN(3);
    chk("R8 reset again", ampReset, 1);
    tick(); tick();
    slpS3N = 0;
    waitN(2);
    tick();
    chk("R7 sleep wins over tick", sleepState, 1);
    chk("R7 no step on collision", ampReset, 0);
    chk("R7 core only", railEn, 5'b00001);

    slpS3N = 1; waitN(3);
    slpS5N = 0; waitN(3);
    chk("R9 off via slpS5N", sleepState, 0);
    chk("R9 all rails off", railEn, 0);
    chk("R10 pg low in S5", pgDriveLow, 1);
    slpS5N = 1; waitN(3);
    chk("R2 back to S0", sleepState, 2);
    stbyOk = 0; waitN(3);
    chk("R9 off via stbyOk", sleepState, 0);
    chk("R9 amp reset cleared", ampReset, 0);
    stbyOk = 1; slpS3N = 0; slpS5N = 0; waitN(3);
    chk("R9 both requests give S5", sleepState, 0);
    waitN(2);
    finishRun();
  end

endmodule